// File: doc/BRIEF.md
# Repeating SPI Shift Sequencer

This block drives a daisy-chained serial shift register. A host fills a byte-addressed transmit buffer, programs a bit count, an idle gap and a repetition count, and then triggers the sequence. The block then shifts the programmed number of bits out on the serial data line, most significant bit first, starting at byte 0. It produces one serial clock pulse per bit and captures the returning serial data into a byte-addressed receive buffer.

A sequence is a number of repetitions of the same transfer. The chip-enable line is released for a programmed number of clock cycles between repetitions. A repetition count of zero makes the sequence run until a soft reset. A sequence is started either by a software start bit or, if the trigger enable bit is set, by a one-cycle pulse on the hardware trigger input. A done bit reports that the sequence has finished. The serial clock runs at half the system clock.

Host map (8-bit address, 8-bit data, reads return data one cycle after the address):

| Address | Access | Contents |
|---|---|---|
| 0x00 | write | bit0 soft reset, bit1 start |
| 0x00 | read | bit0 done, bit1 trigger enable |
| 0x01 | read/write | bit0 trigger enable |
| 0x02 / 0x03 | read/write | bit count, low / high byte |
| 0x04 / 0x05 | read/write | gap cycles, low / high byte |
| 0x06 | read/write | repetition count |
| 0x40 + i | write | transmit byte i |
| 0x80 + i | read | receive byte i |

Top module: `spi_seq`

## Requirements
- R1: Bit k of a transfer, for k counted from 0, is transmit byte k/8, bit position 7-(k mod 8). It is driven on sdo. sdo changes only when sclk falls or when chip_en rises. sdo returns to 0 after the last bit.
- R2: sdi is captured at each rising sclk. Bit k is stored into receive byte k/8 at bit position 7-(k mod 8). In a final partial byte, the bit positions that were not shifted read 0.
- R3: Each repetition holds chip_en high for exactly 2*N clock cycles, where N is the bit count. It gives exactly N sclk pulses, one cycle high and one cycle low. sclk is high only while chip_en is high.
- R4: Between repetitions, chip_en is low for exactly G+1 clock cycles, where G is the gap register.
- R5: A nonzero repetition count M gives exactly M repetitions. The done bit sets on the clock edge at which chip_en falls for the last time.
- R6: A repetition count of 0 repeats the transfer without end, and done stays 0.
- R7: Writing 1 to bit1 at 0x00 raises chip_en on the same clock edge. A high cycle of ext_trig starts a sequence the same way only when the trigger enable bit is 1.
- R8: done reads 1 after reset and clears when a sequence starts.
- R9: Writing 1 to bit0 at 0x00 returns the block to idle on that edge: chip_en, sclk and sdo are 0 and done is 1. The configuration registers keep their values.
- R10: A start request while a sequence is running is ignored.
- R11: With a bit count of 0, a start produces no chip_en or sclk activity, and done stays 1.
- R12: The configuration registers read back what was written. Reset values are: bit count 0, gap 0, repetition count 1, trigger enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, one cycle after the address |
| ext_trig | input | 1 | Hardware start pulse |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| chip_en | output | 1 | Active-high chip enable |

## Verification
A start that the engine accepts raises chip_en on the edge that takes the start write or trigger. The first sclk rise follows one cycle later and the next bit comes every two cycles. chip_en and done change on edge 2N, and each later repetition begins G+1 cycles after the previous one ends. Register and buffer reads return data one edge after the address is presented. The bench changes inputs and samples outputs on falling clock edges. It counts the exact number of edges from the write that caused each effect before it samples. A monitor running on rising clock edges measures the high and low lengths of chip_en and counts the repetitions, so that every window is checked to the cycle.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;

  // register offsets inside the register region
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_TRIGEN = 1;
  localparam int unsigned OFS_SIZE_L = 2;
  localparam int unsigned OFS_SIZE_H = 3;
  localparam int unsigned OFS_GAP_L  = 4;
  localparam int unsigned OFS_GAP_H  = 5;
  localparam int unsigned OFS_REP    = 6;

  // region select, top two address bits
  localparam logic [1:0] RGN_REGS = 2'b00;
  localparam logic [1:0] RGN_TX   = 2'b01;
  localparam logic [1:0] RGN_RX   = 2'b10;

endpackage

// File: rtl/spi_seq_ram.sv
module spi_seq_ram #(
  parameter int unsigned DEPTH   = 16,
  parameter bit          SYNC_RD = 1'b1,
  parameter int unsigned AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (SYNC_RD) begin : g_sync
      logic [7:0] q;
      always_ff @(posedge clk) q <= mem[raddr];
      assign rdata = q;
    end else begin : g_async
      assign rdata = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              done,
  output logic              soft_rst,
  output logic              sw_start,
  output logic              trig_en,
  output logic [CNT_W-1:0]  size,
  output logic [CNT_W-1:0]  gap_len,
  output logic [REP_W-1:0]  rep_total,
  output logic              tx_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              rd_rx_q,
  output logic [7:0]        reg_rdata_q
);

  localparam int unsigned OFS_W = ADDR_W - 2;

  logic [1:0]       rgn;
  logic [OFS_W-1:0] ofs;
  logic             in_regs;
  logic [7:0]       rd_mux;

  assign rgn     = bus_addr[ADDR_W-1 -: 2];
  assign ofs     = bus_addr[OFS_W-1:0];
  assign in_regs = (rgn == RGN_REGS);
  assign buf_idx = bus_addr[IDX_W-1:0];
  assign tx_we   = bus_we && (rgn == RGN_TX);

  function automatic logic hit(input int unsigned off);
    return in_regs && (ofs == OFS_W'(off));
  endfunction

  assign soft_rst = bus_we && hit(OFS_CTRL) && bus_wdata[0];
  assign sw_start = bus_we && hit(OFS_CTRL) && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_en   <= 1'b0;
      size      <= '0;
      gap_len   <= '0;
      rep_total <= REP_W'(1);
    end else if (bus_we) begin
      if (hit(OFS_TRIGEN)) trig_en <= bus_wdata[0];
      if (hit(OFS_SIZE_L)) size[7:0] <= bus_wdata;
      if (hit(OFS_SIZE_H)) size[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
      if (hit(OFS_GAP_L))  gap_len[7:0] <= bus_wdata;
      if (hit(OFS_GAP_H))  gap_len[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
      if (hit(OFS_REP))    rep_total <= REP_W'(bus_wdata);
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (hit(OFS_CTRL))   rd_mux = {6'd0, trig_en, done};
    if (hit(OFS_TRIGEN)) rd_mux = {7'd0, trig_en};
    if (hit(OFS_SIZE_L)) rd_mux = size[7:0];
    if (hit(OFS_SIZE_H)) rd_mux = 8'(size >> 8);
    if (hit(OFS_GAP_L))  rd_mux = gap_len[7:0];
    if (hit(OFS_GAP_H))  rd_mux = 8'(gap_len >> 8);
    if (hit(OFS_REP))    rd_mux = 8'(rep_total);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_q <= 8'h00;
      rd_rx_q     <= 1'b0;
    end else begin
      reg_rdata_q <= rd_mux;
      rd_rx_q     <= (rgn == RGN_RX);
    end
  end

  // configuration survives a soft reset
  assert_cfg_kept_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (size == $past(size) && gap_len == $past(gap_len) &&
                  rep_total == $past(rep_total)));

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             go,
  input  logic [CNT_W-1:0] size,
  input  logic [CNT_W-1:0] gap_len,
  input  logic [REP_W-1:0] rep_total,
  output logic [IDX_W-1:0] tx_idx,
  input  logic [7:0]       tx_byte,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic [7:0]       rx_byte,
  input  logic             sdi,
  output logic             sclk,
  output logic             sdo,
  output logic             chip_en,
  output logic             done
);

  localparam int unsigned BI_W = IDX_W + 3;

  seq_state_t       state;
  logic             ph;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] gap_cnt;
  logic [REP_W-1:0] rep_cnt;
  logic [7:0]       rx_acc;

  logic [BI_W-1:0]  nxt_bit;
  logic             nxt_val;
  logic             last;
  logic             more;
  logic [7:0]       acc_next;

  // bit loaded onto sdo at the next load edge
  assign nxt_bit = (state == ST_SHIFT) ? (bit_cnt[BI_W-1:0] + 1'b1) : '0;
  assign tx_idx  = nxt_bit[BI_W-1:3];
  assign nxt_val = tx_byte[3'd7 - nxt_bit[2:0]];

  assign last     = (bit_cnt == size - 1'b1);
  assign more     = (rep_total == '0) || (REP_W'(rep_cnt + 1'b1) != rep_total);
  assign acc_next = {rx_acc[6:0], sdi};

  // capture happens on the edge that raises sclk
  assign rx_we   = (state == ST_SHIFT) && !ph && ((bit_cnt[2:0] == 3'd7) || last);
  assign rx_idx  = bit_cnt[BI_W-1:3];
  assign rx_byte = (bit_cnt[2:0] == 3'd7) ? acc_next
                                          : (acc_next << (3'd7 - bit_cnt[2:0]));

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state   <= ST_IDLE;
      ph      <= 1'b0;
      bit_cnt <= '0;
      gap_cnt <= '0;
      rep_cnt <= '0;
      rx_acc  <= '0;
      sclk    <= 1'b0;
      sdo     <= 1'b0;
      chip_en <= 1'b0;
      done    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go && size != '0) begin
            state   <= ST_SHIFT;
            done    <= 1'b0;
            chip_en <= 1'b1;
            sdo     <= nxt_val;
            bit_cnt <= '0;
            ph      <= 1'b0;
            rep_cnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (!ph) begin
            sclk   <= 1'b1;
            ph     <= 1'b1;
            rx_acc <= acc_next;
          end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            if (last) begin
              chip_en <= 1'b0;
              sdo     <= 1'b0;
              if (more) begin
                state   <= ST_GAP;
                gap_cnt <= '0;
                rep_cnt <= rep_cnt + 1'b1;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              sdo     <= nxt_val;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == gap_len) begin
            state   <= ST_SHIFT;
            chip_en <= 1'b1;
            sdo     <= nxt_val;
            bit_cnt <= '0;
            ph      <= 1'b0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> chip_en);

  assert_sdo_moves_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> ($fell(sclk) || $rose(chip_en) || $past(soft_rst)));

  assert_gap_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (!chip_en && !sclk));

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!chip_en && !sclk));

  assert_forever_no_done_R6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && rep_total == '0 && !soft_rst) |=> !done);

  assert_start_clears_done_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && go && size != '0 && !soft_rst) |=> (!done && chip_en));

  assert_soft_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!chip_en && !sclk && !sdo && done));

endmodule

// File: rtl/spi_seq.sv
module spi_seq #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BUF_BYTES = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned REP_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ext_trig,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              chip_en
);

  localparam int unsigned IDX_W = $clog2(BUF_BYTES);

  logic             soft_rst, sw_start, trig_en, done, tx_we, rd_rx_q;
  logic [CNT_W-1:0] size, gap_len;
  logic [REP_W-1:0] rep_total;
  logic [IDX_W-1:0] buf_idx, tx_idx, rx_idx;
  logic [7:0]       reg_rdata_q, tx_byte, rx_byte, rx_rdata;
  logic             rx_we, go;

  assign go = sw_start || (trig_en && ext_trig);

  spi_seq_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .REP_W(REP_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .done(done), .soft_rst(soft_rst),
    .sw_start(sw_start), .trig_en(trig_en), .size(size), .gap_len(gap_len),
    .rep_total(rep_total), .tx_we(tx_we), .buf_idx(buf_idx),
    .rd_rx_q(rd_rx_q), .reg_rdata_q(reg_rdata_q)
  );

  spi_seq_ram #(.DEPTH(BUF_BYTES), .SYNC_RD(1'b0), .AW(IDX_W)) u_txbuf (
    .clk(clk), .we(tx_we), .waddr(buf_idx), .wdata(bus_wdata),
    .raddr(tx_idx), .rdata(tx_byte)
  );

  spi_seq_ram #(.DEPTH(BUF_BYTES), .SYNC_RD(1'b1), .AW(IDX_W)) u_rxbuf (
    .clk(clk), .we(rx_we), .waddr(rx_idx), .wdata(rx_byte),
    .raddr(buf_idx), .rdata(rx_rdata)
  );

  spi_seq_engine #(.IDX_W(IDX_W), .CNT_W(CNT_W), .REP_W(REP_W)) u_engine (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .go(go), .size(size),
    .gap_len(gap_len), .rep_total(rep_total), .tx_idx(tx_idx),
    .tx_byte(tx_byte), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .sdi(sdi), .sclk(sclk), .sdo(sdo), .chip_en(chip_en), .done(done)
  );

  assign bus_rdata = rd_rx_q ? rx_rdata : reg_rdata_q;

endmodule

// File: tb/spi_seq_test.sv
module spi_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_trig = 1'b0;
  logic       sclk, sdo, chip_en;
  logic       sdi = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_seq uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .chip_en(chip_en)
  );

  // slave model: takes sdo on sclk rise, moves sdi on sclk fall
  logic slv_bits [256];
  int   slv_cnt = 0;
  logic pat [256];
  int   sptr = 0;
  int   sclk_rises = 0;

  always @(posedge sclk) begin
    slv_bits[slv_cnt % 256] = sdo;
    slv_cnt++;
    sclk_rises++;
  end
  always @(posedge chip_en) begin
    sptr = 0;
    sdi = pat[0];
  end
  always @(negedge sclk) begin
    sptr++;
    sdi = pat[sptr % 256];
  end

  // chip-enable monitor on rising clock edges
  int  frames = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_gap = 0;
  logic ce_prev = 1'b0;
  always @(posedge clk) begin
    if (chip_en && !ce_prev) begin
      frames++;
      last_gap = lo_run;
    end
    if (chip_en) begin
      hi_run++;
      lo_run = 0;
    end else begin
      if (ce_prev) last_hi = hi_run;
      hi_run = 0;
      lo_run++;
    end
    ce_prev = chip_en;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic clear_mon();
    frames = 0; slv_cnt = 0; sclk_rises = 0;
  endtask

  task automatic set_pat(input int seed);
    for (int i = 0; i < 256; i++) pat[i] = ((i * 7 + seed) % 5) < 2;
  endtask

  task automatic wait_done();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(8'h00, v);
      if (v[0]) break;
    end
  endtask

  task automatic config_seq(input int nbits, input int gap, input int rep);
    wr(8'h02, 8'(nbits)); wr(8'h03, 8'(nbits >> 8));
    wr(8'h04, 8'(gap));   wr(8'h05, 8'(gap >> 8));
    wr(8'h06, 8'(rep));
  endtask

  function automatic int rx_exp(input int j, input int nbits);
    int v = 0;
    for (int i = 0; i < 8; i++)
      if (8 * j + i < nbits && pat[8 * j + i]) v |= (1 << (7 - i));
    return v;
  endfunction

  // R8, R12: reset state and register readback
  task automatic t_reset_regs();
    logic [7:0] v;
    chk("R9", "chip_en after reset", chip_en, 0);
    chk("R9", "sclk after reset", sclk, 0);
    rd(8'h00, v); chk("R8", "done after reset", v[0], 1);
    rd(8'h06, v); chk("R12", "repeat reset value", v, 1);
    rd(8'h02, v); chk("R12", "size reset value", v, 0);
    rd(8'h01, v); chk("R12", "enable reset value", v, 0);
    config_seq(16'h0123, 16'h0456, 8'h07);
    rd(8'h03, v); chk("R12", "size high readback", v, 8'h01);
    rd(8'h02, v); chk("R12", "size low readback", v, 8'h23);
    rd(8'h05, v); chk("R12", "gap high readback", v, 8'h04);
    rd(8'h06, v); chk("R12", "repeat readback", v, 7);
  endtask

  // R1, R2, R3, R5: one 16-bit transfer
  task automatic t_single16();
    logic [7:0] v;
    logic [7:0] txb [2] = '{8'hA5, 8'h3C};
    wr(8'h40, txb[0]); wr(8'h41, txb[1]);
    config_seq(16, 0, 1);
    set_pat(3); clear_mon();
    wr(8'h00, 8'h02);
    chk("R7", "chip_en on start edge", chip_en, 1);
    chk("R1", "first sdo bit", sdo, 1);
    repeat (31) @(negedge clk);
    chk("R3", "chip_en at cycle 2N-1", chip_en, 1);
    @(negedge clk);
    chk("R3", "chip_en off at cycle 2N", chip_en, 0);
    chk("R1", "sdo idle after last bit", sdo, 0);
    chk("R3", "sclk pulses", sclk_rises, 16);
    for (int k = 0; k < 16; k++)
      chk("R1", $sformatf("sdo bit %0d", k), slv_bits[k], txb[k / 8][7 - k % 8]);
    rd(8'h00, v); chk("R5", "done after single", v[0], 1);
    rd(8'h80, v); chk("R2", "rx byte 0", v, rx_exp(0, 16));
    rd(8'h81, v); chk("R2", "rx byte 1", v, rx_exp(1, 16));
  endtask

  // R2: partial final byte
  task automatic t_partial11();
    logic [7:0] v;
    wr(8'h40, 8'h5A); wr(8'h41, 8'hF0);
    config_seq(11, 0, 1);
    set_pat(1); clear_mon();
    wr(8'h00, 8'h02);
    wait_done();
    chk("R3", "sclk pulses 11 bits", sclk_rises, 11);
    chk("R1", "bit 9 on sdo", slv_bits[9], 1);
    rd(8'h80, v); chk("R2", "rx byte 0 of 11", v, rx_exp(0, 11));
    rd(8'h81, v); chk("R2", "rx partial byte zero-filled", v, rx_exp(1, 11));
  endtask

  // R4, R5: three repetitions with a gap of 5
  task automatic t_repeat3();
    logic [7:0] v;
    config_seq(4, 5, 3);
    clear_mon();
    wr(8'h00, 8'h02);
    repeat (35) @(negedge clk);
    chk("R5", "chip_en in last repetition", chip_en, 1);
    rd(8'h00, v); chk("R5", "done set at end of last repetition", v[0], 1);
    chk("R5", "repetition count", frames, 3);
    chk("R3", "chip_en high length", last_hi, 8);
    chk("R4", "gap length", last_gap, 6);
    chk("R3", "sclk pulses over 3 reps", sclk_rises, 12);
  endtask

  // R7: hardware trigger gated by enable
  task automatic t_trigger();
    clear_mon();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7", "trigger ignored when disabled", frames, 0);
    wr(8'h01, 8'h01);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    chk("R7", "trigger starts when enabled", chip_en, 1);
    wait_done();
    chk("R7", "trigger sequence repetitions", frames, 3);
    wr(8'h01, 8'h00);
  endtask

  // R6, R9: forever mode and soft reset
  task automatic t_forever();
    logic [7:0] v;
    config_seq(4, 2, 0);
    clear_mon();
    wr(8'h00, 8'h02);
    repeat (100) @(negedge clk);
    chk("R6", "forever repetitions in 100 cycles", frames, 10);
    rd(8'h00, v); chk("R6", "done stays low in forever mode", v[0], 0);
    wr(8'h00, 8'h01);
    chk("R9", "chip_en after soft reset", chip_en, 0);
    chk("R9", "sclk after soft reset", sclk, 0);
    chk("R9", "sdo after soft reset", sdo, 0);
    rd(8'h00, v); chk("R9", "done after soft reset", v[0], 1);
    rd(8'h02, v); chk("R9", "size kept", v, 4);
    rd(8'h04, v); chk("R9", "gap kept", v, 2);
  endtask

  // R10: start while busy ignored
  task automatic t_busy();
    config_seq(8, 3, 2);
    clear_mon();
    wr(8'h00, 8'h02);
    repeat (5) @(negedge clk);
    wr(8'h00, 8'h02);
    wait_done();
    chk("R10", "repetitions with extra start", frames, 2);
    chk("R10", "sclk pulses with extra start", sclk_rises, 16);
  endtask

  // R11: zero bit count
  task automatic t_zero();
    logic [7:0] v;
    config_seq(0, 0, 1);
    clear_mon();
    wr(8'h00, 8'h02);
    chk("R11", "chip_en with zero size", chip_en, 0);
    repeat (4) @(negedge clk);
    chk("R11", "no frames with zero size", frames, 0);
    chk("R11", "no sclk with zero size", sclk_rises, 0);
    rd(8'h00, v); chk("R11", "done with zero size", v[0], 1);
  endtask

  initial begin
    set_pat(0);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset_regs();
    t_single16();
    t_partial11();
    t_repeat3();
    t_trigger();
    t_forever();
    t_busy();
    t_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule